// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block drives a three-wire serial EEPROM from a system clock. It generates chip select (`ew_cs`), serial clock (`ew_sk`) and serial data out (`ew_di`), and it samples the memory's data line (`ew_do`). One request carries an operation, an address, write data, a word count for reads and an organisation flag that picks 16-bit or 8-bit words. The block turns the request into a serial frame whose length depends on both the operation and the organisation. It sends the frame, gathers read words one at a time and shows each with a one-cycle strobe. It ends with a one-cycle `done` pulse. `err` rises together with `done` when the memory never reported ready.

After a frame that starts a programming cycle (write, erase, erase-all, write-all), the block drops chip select for the minimum low time. It then raises chip select again and watches `ew_do` until it reads high. When ready is seen, it clocks in one start bit and drops chip select, which removes the status from the memory's output. The serial clock high time, low time, chip-select setup time, minimum chip-select low time and the delay of the read sample point are all divider counts in system clocks.

Top module: `mw_eeprom_host`

## Requirements
- R1: While reset is held, and in idle, `ew_cs`, `ew_sk` and `ew_di` are low, `req_ready` is high, and `done` and `rd_valid` are low.
- R2: `req_op` encodes 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 program-enable, 6 program-disable. Each frame sends, MSB first, a start bit of 1, then a 2-bit opcode, then the address field (10 bits in 16-bit mode, 11 bits in 8-bit mode), then write data (16 or 8 bits) for write and write-all only.
- R3: A frame has 13 clocks (16-bit mode) or 14 clocks (8-bit mode) when it carries no data. Write, write-all and a one-word read take 29 clocks (16-bit) or 22 clocks (8-bit). Each extra read word adds 16 or 8 clocks.
- R4: `ew_cs` rises only while `ew_sk` is low. `ew_sk` stays low while `ew_cs` is low. `ew_di` does not change while `ew_sk` is high.
- R5: Each time `ew_cs` rises, it has been low for at least `CSL_CYC` system clocks.
- R6: On a read, the bit the memory returns on the last address clock is discarded. Each word is then taken MSB first on the following 16 or 8 clocks, sampled `SMP_DLY` system clocks after each rising `ew_sk`. `rd_data` shows the word, zero-extended in 8-bit mode, while `rd_valid` is high for one cycle.
- R7: A read keeps `ew_cs` high and returns exactly `req_cnt` consecutive words. A count of 0 returns one word.
- R8: After a write, erase, erase-all or write-all frame, the block drops `ew_cs` for the minimum low time and raises it again. It then samples `ew_do` after `CSS_CYC` cycles and keeps polling while `ew_do` is low. `done` is not given before the memory reports ready.
- R9: When `ew_do` reads high during polling, the block sends one clock with `ew_di` high and then drops `ew_cs`.
- R10: If ready is not seen within `POLL_LIMIT` polling cycles, the block drops `ew_cs` and finishes with `err` high together with `done`.
- R11: Read, program-enable and program-disable finish with no polling and no start-bit clear, and with `err` low.
- R12: The opcode is 10 for read, 01 for write and 11 for erase. The other four operations use opcode 00, and the top two address-field bits select among them: 11 program-enable, 10 erase-all, 01 write-all, 00 program-disable. The remaining address bits are sent as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted while `req_ready` is high |
| req_op | input | 3 | Operation code (R2) |
| req_addr | input | 11 | Word address; bits [9:0] used in 16-bit mode |
| req_wdata | input | 16 | Write data; bits [7:0] used in 8-bit mode |
| req_cnt | input | CNT_W | Number of words for a read |
| req_x16 | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| req_ready | output | 1 | Block idle and able to take a request |
| rd_data | output | 16 | Read word |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| done | output | 1 | One-cycle pulse when a request finishes |
| err | output | 1 | High with `done` when polling timed out |
| ew_cs | output | 1 | Chip select to the memory |
| ew_sk | output | 1 | Serial clock to the memory |
| ew_di | output | 1 | Serial data to the memory |
| ew_do | input | 1 | Serial data and status from the memory |

## Verification
A bit counter that is one step off shows up at once as the wrong number of serial clocks in the frame. On a read it also shows as a word shifted by one bit, caused by the dummy zero being kept or a real bit being dropped, and this is visible on the first `rd_valid`. A mistake in the poll sequencer shows within one busy period: `done` arrives before the memory's busy time has passed, the clearing start bit is missing, or an early timeout raises `err`. A wrong opcode or mode selector only shows later, when the following read returns data the memory should or should not have written.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int HDR_W   = 3;
    localparam int A16_W   = 10;
    localparam int A8_W    = 11;
    localparam int D16_W   = 16;
    localparam int D8_W    = 8;
    localparam int FRAME_W = HDR_W + A16_W + D16_W;
    localparam int BITS_W  = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_ERAL  = 3'd3,
        OP_WRAL  = 3'd4,
        OP_EWEN  = 3'd5,
        OP_EWDS  = 3'd6
    } mw_op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_LEAD, S_LO, S_HI, S_GAP, S_POLL
    } mw_state_e;
endpackage

// File: rtl/mw_frame_gen.sv
module mw_frame_gen
    import mw_pkg::*;
(
    input  mw_op_e                   op,
    input  logic                     x16,
    input  logic [A8_W-1:0]          addr,
    input  logic [D16_W-1:0]         wdata,
    output logic [FRAME_W-1:0]       frame,
    output logic [BITS_W-1:0]        nbits,
    output logic                     needs_poll,
    output logic                     is_read
);
    logic [1:0]       opc;
    logic [1:0]       sel;
    logic             has_data;
    logic [A16_W-1:0] a16;
    logic [A8_W-1:0]  a8;

    always_comb begin
        opc        = 2'b00;
        sel        = 2'b00;
        has_data   = 1'b0;
        needs_poll = 1'b0;
        is_read    = 1'b0;
        case (op)
            OP_READ:  begin opc = 2'b10; is_read = 1'b1; end
            OP_WRITE: begin opc = 2'b01; has_data = 1'b1; needs_poll = 1'b1; end
            OP_ERASE: begin opc = 2'b11; needs_poll = 1'b1; end
            OP_ERAL:  begin sel = 2'b10; needs_poll = 1'b1; end
            OP_WRAL:  begin sel = 2'b01; has_data = 1'b1; needs_poll = 1'b1; end
            OP_EWEN:  sel = 2'b11;
            default:  sel = 2'b00;
        endcase
        // opcode 00 borrows the two top address bits as a sub-command
        a16 = (opc == 2'b00) ? {sel, {(A16_W-2){1'b0}}} : addr[A16_W-1:0];
        a8  = (opc == 2'b00) ? {sel, {(A8_W-2){1'b0}}}  : addr;
        if (x16) begin
            frame = {1'b1, opc, a16, wdata};
            nbits = BITS_W'(has_data ? HDR_W + A16_W + D16_W : HDR_W + A16_W);
        end else begin
            frame = {1'b1, opc, a8, wdata[D8_W-1:0], {(FRAME_W-HDR_W-A8_W-D8_W){1'b0}}};
            nbits = BITS_W'(has_data ? HDR_W + A8_W + D8_W : HDR_W + A8_W);
        end
    end
endmodule

// File: rtl/mw_rd_collect.sv
module mw_rd_collect
    import mw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic             last,
    input  logic             din,
    input  logic             x16,
    output logic [D16_W-1:0] rd_data,
    output logic             rd_valid
);
    typedef struct packed {
        logic [D16_W-1:0] sh;
        logic [D16_W-1:0] data;
        logic             vld;
    } col_t;

    col_t q, d;
    logic [D16_W-1:0] nxt;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        nxt   = {q.sh[D16_W-2:0], din};
        if (cap) begin
            d.sh = nxt;
            if (last) begin
                d.data = x16 ? nxt : {{(D16_W-D8_W){1'b0}}, nxt[D8_W-1:0]};
                d.vld  = 1'b1;
                d.sh   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data  = q.data;
    assign rd_valid = q.vld;

    // a word needs several serial clocks, so the strobe never lasts two cycles
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
    import mw_pkg::*;
#(
    parameter int CLK_LO_CYC = 3,
    parameter int CLK_HI_CYC = 3,
    parameter int CSS_CYC    = 2,
    parameter int CSL_CYC    = 4,
    parameter int SMP_DLY    = 1,
    parameter int POLL_LIMIT = 20000,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [10:0]      req_addr,
    input  logic [15:0]      req_wdata,
    input  logic [CNT_W-1:0] req_cnt,
    input  logic             req_x16,
    output logic             req_ready,
    output logic [15:0]      rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic             err,
    output logic             ew_cs,
    output logic             ew_sk,
    output logic             ew_di,
    input  logic             ew_do
);
    localparam int M1     = (CLK_LO_CYC > CLK_HI_CYC) ? CLK_LO_CYC : CLK_HI_CYC;
    localparam int M2     = (CSS_CYC > CSL_CYC) ? CSS_CYC : CSL_CYC;
    localparam int TMR_W  = $clog2(((M1 > M2) ? M1 : M2) + 1);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        mw_state_e          st;
        logic               cs;
        logic               sk;
        logic               di;
        logic [TMR_W-1:0]   tmr;
        logic [FRAME_W-1:0] sh;
        logic [BITS_W-1:0]  cmd_left;
        logic [4:0]         rbit;
        logic [CNT_W-1:0]   words;
        logic               x16;
        logic               rd;
        logic               poll_pend;
        logic               fail;
        logic               done;
        logic               err;
        logic [POLL_W-1:0]  pcnt;
    } ctl_t;

    ctl_t q, d;
    logic [FRAME_W-1:0] fg_frame;
    logic [BITS_W-1:0]  fg_nbits;
    logic               fg_poll, fg_read;
    logic               cap, cap_last;

    mw_frame_gen i_frame (
        .op(mw_op_e'(req_op)), .x16(req_x16), .addr(req_addr), .wdata(req_wdata),
        .frame(fg_frame), .nbits(fg_nbits), .needs_poll(fg_poll), .is_read(fg_read)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.err    = 1'b0;
        d.tmr    = q.tmr + 1'b1;
        cap      = 1'b0;
        cap_last = 1'b0;
        case (q.st)
            S_IDLE: begin
                d.tmr = '0;
                if (req_valid) begin
                    d.sh        = fg_frame;
                    d.cmd_left  = fg_nbits;
                    d.x16       = req_x16;
                    d.rd        = fg_read;
                    d.poll_pend = fg_poll;
                    d.words     = (req_cnt == '0) ? CNT_W'(1) : req_cnt;
                    d.fail      = 1'b0;
                    d.cs        = 1'b1;
                    d.st        = S_LEAD;
                end
            end
            S_LEAD: if (q.tmr == TMR_W'(CSS_CYC - 1)) begin
                d.tmr = '0;
                d.di  = q.sh[FRAME_W-1];
                d.st  = S_LO;
            end
            S_LO: if (q.tmr == TMR_W'(CLK_LO_CYC - 1)) begin
                d.tmr = '0;
                d.sk  = 1'b1;
                d.st  = S_HI;
            end
            S_HI: begin
                // command clocks (incl. the dummy-zero clock) are never captured
                if (q.tmr == TMR_W'(SMP_DLY) && q.cmd_left == '0) begin
                    cap      = 1'b1;
                    cap_last = (q.rbit == 5'd1);
                end
                if (q.tmr == TMR_W'(CLK_HI_CYC - 1)) begin
                    d.tmr = '0;
                    d.sk  = 1'b0;
                    d.st  = S_LO;
                    if (q.cmd_left > BITS_W'(1)) begin
                        d.cmd_left = q.cmd_left - 1'b1;
                        d.sh       = q.sh << 1;
                        d.di       = d.sh[FRAME_W-1];
                    end else if (q.cmd_left == BITS_W'(1)) begin
                        d.cmd_left = '0;
                        d.di       = 1'b0;
                        d.rbit     = q.x16 ? 5'd16 : 5'd8;
                        if (!q.rd) begin
                            d.cs = 1'b0;
                            d.st = S_GAP;
                        end
                    end else if (q.rbit > 5'd1) begin
                        d.rbit = q.rbit - 1'b1;
                    end else if (q.words > CNT_W'(1)) begin
                        d.words = q.words - 1'b1;
                        d.rbit  = q.x16 ? 5'd16 : 5'd8;
                    end else begin
                        d.cs = 1'b0;
                        d.st = S_GAP;
                    end
                end
            end
            S_GAP: if (q.tmr == TMR_W'(CSL_CYC - 1)) begin
                d.tmr = '0;
                if (q.poll_pend) begin
                    d.poll_pend = 1'b0;
                    d.pcnt      = '0;
                    d.cs        = 1'b1;
                    d.st        = S_POLL;
                end else begin
                    d.done = 1'b1;
                    d.err  = q.fail;
                    d.fail = 1'b0;
                    d.st   = S_IDLE;
                end
            end
            S_POLL: begin
                d.pcnt = q.pcnt + 1'b1;
                if (q.tmr == TMR_W'(CSS_CYC - 1)) begin
                    d.tmr = q.tmr;
                    if (ew_do) begin
                        // one start bit clears the status from the data line
                        d.sh       = {1'b1, {(FRAME_W-1){1'b0}}};
                        d.cmd_left = BITS_W'(1);
                        d.rd       = 1'b0;
                        d.di       = 1'b1;
                        d.tmr      = '0;
                        d.st       = S_LO;
                    end else if (q.pcnt >= POLL_W'(POLL_LIMIT - 1)) begin
                        d.fail = 1'b1;
                        d.cs   = 1'b0;
                        d.tmr  = '0;
                        d.st   = S_GAP;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end

    mw_rd_collect i_collect (
        .clk(clk), .rst_n(rst_n), .cap(cap), .last(cap_last), .din(ew_do),
        .x16(q.x16), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    assign req_ready = (q.st == S_IDLE);
    assign done      = q.done;
    assign err       = q.err;
    assign ew_cs     = q.cs;
    assign ew_sk     = q.sk;
    assign ew_di     = q.di;

    // checker state: chip-select low run length, saturating
    logic [TMR_W-1:0] lowcnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                              lowcnt_q <= TMR_W'(CSL_CYC);
        else if (ew_cs)                          lowcnt_q <= '0;
        else if (lowcnt_q < TMR_W'(CSL_CYC))     lowcnt_q <= lowcnt_q + 1'b1;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ew_cs && !ew_sk && !ew_di));
    assert_cs_rise_sk_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ew_cs) |-> !ew_sk);
    assert_no_sk_when_deselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ew_cs |-> !ew_sk);
    assert_di_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ew_sk && $past(ew_sk)) |-> $stable(ew_di));
    assert_cs_low_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ew_cs) |-> (lowcnt_q >= TMR_W'(CSL_CYC)));
    assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    assert_done_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ew_cs);
endmodule

// File: tb/test_mw_eeprom_host.sv
module test_mw_eeprom_host;
    localparam int CLK_PERIOD = 10;
    localparam int POLL_LIM   = 300;
    localparam int CSL        = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [10:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [7:0]  req_cnt = '0;
    logic        req_x16 = 1'b0;
    logic        req_ready, rd_valid, done, err, ew_cs, ew_sk, ew_di;
    logic [15:0] rd_data;
    logic        ew_do = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_eeprom_host #(.CLK_LO_CYC(3), .CLK_HI_CYC(3), .CSS_CYC(2), .CSL_CYC(CSL),
                     .SMP_DLY(1), .POLL_LIMIT(POLL_LIM), .CNT_W(8)) i_mw_eeprom_host (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_cnt(req_cnt), .req_x16(req_x16),
        .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
        .err(err), .ew_cs(ew_cs), .ew_sk(ew_sk), .ew_di(ew_di), .ew_do(ew_do)
    );

    // ---------------- memory model (driven only here) ----------------
    logic        mx16 = 1'b1;
    int          busy_len = 60;
    logic [15:0] mem [0:2047];
    logic        cs_p = 1'b0, sk_p = 1'b0, di_p = 1'b0;
    int          mst = 0, nb = 0, rb = 0, busy = 0;
    logic [28:0] sr = '0;
    logic [10:0] ma = '0;
    logic [1:0]  mop, msel;
    logic [15:0] cur = '0, dat;
    logic        we = 1'b0, armed = 1'b0, dout = 1'b0, is_wral = 1'b0;
    int          sess_clks = 0, last_clks = 0, clears = 0;
    int          di_glitch = 0, cs_sk_bad = 0, csl_bad = 0, lowrun = 100;

    always @(negedge clk) begin
        int aw, dw;
        aw = mx16 ? 10 : 11;
        dw = mx16 ? 16 : 8;
        if (busy > 0) busy--;
        if (ew_sk && sk_p && (ew_di != di_p)) di_glitch++;
        if (ew_cs && !cs_p) begin
            if (ew_sk) cs_sk_bad++;
            if (lowrun < CSL) csl_bad++;
            mst = 0; sess_clks = 0;
        end
        if (!ew_cs && cs_p && sess_clks > 1) last_clks = sess_clks;
        lowrun = ew_cs ? 0 : lowrun + 1;
        if (ew_cs && ew_sk && !sk_p) begin
            sess_clks++;
            case (mst)
                0: if (ew_di) begin
                    mst = 1; nb = 0; sr = '0;
                    if (armed && busy == 0) clears++;
                    armed = 1'b0;
                end
                1: begin
                    sr = {sr[27:0], ew_di}; nb++;
                    if (nb == 2 + aw) begin
                        mop  = 2'(sr >> aw);
                        ma   = mx16 ? {1'b0, sr[9:0]} : sr[10:0];
                        msel = mx16 ? sr[9:8] : sr[10:9];
                        mst  = 4;
                        if (mop == 2'b10) begin
                            cur = mx16 ? mem[ma[9:0]] : {8'h00, mem[ma][7:0]};
                            rb = 0; dout = 1'b0; mst = 3;
                        end else if (mop == 2'b11) begin
                            if (we) begin
                                if (mx16) mem[ma[9:0]] = 16'hFFFF; else mem[ma][7:0] = 8'hFF;
                            end
                            busy = we ? busy_len : 0; armed = 1'b1;
                        end else if (mop == 2'b01) begin
                            is_wral = 1'b0; nb = 0; sr = '0; mst = 2;
                        end else begin
                            case (msel)
                                2'b11: we = 1'b1;
                                2'b00: we = 1'b0;
                                2'b10: begin
                                    if (we) for (int i = 0; i < 2048; i++) mem[i] = 16'hFFFF;
                                    busy = we ? busy_len : 0; armed = 1'b1;
                                end
                                default: begin is_wral = 1'b1; nb = 0; sr = '0; mst = 2; end
                            endcase
                        end
                    end
                end
                2: begin
                    sr = {sr[27:0], ew_di}; nb++;
                    if (nb == dw) begin
                        dat = sr[15:0];
                        if (we) begin
                            if (is_wral) begin
                                for (int i = 0; i < 2048; i++)
                                    if (mx16) mem[i] = dat; else mem[i][7:0] = dat[7:0];
                            end else if (mx16) mem[ma[9:0]] = dat;
                            else mem[ma][7:0] = dat[7:0];
                        end
                        busy = we ? busy_len : 0; armed = 1'b1; mst = 4;
                    end
                end
                3: begin
                    dout = cur[dw-1-rb];
                    rb++;
                    if (rb == dw) begin
                        rb = 0;
                        ma = mx16 ? 11'((ma + 1) & 11'h3FF) : ma + 1'b1;
                        cur = mx16 ? mem[ma[9:0]] : {8'h00, mem[ma][7:0]};
                    end
                end
                default: ;
            endcase
        end
        ew_do = (ew_cs && armed && mst == 0) ? (busy == 0) : (ew_cs && mst == 3 && dout);
        cs_p = ew_cs; sk_p = ew_sk; di_p = ew_di;
    end

    // ---------------- bench bookkeeping ----------------
    int cyc = 0;
    int nchk = 0, nfail = 0;
    int nwords, op_cycles;
    logic got_err;
    logic [15:0] got [0:7];

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                $display("FAIL watchdog: run did not finish, act=hung exp=finished");
                $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail + 1);
                $finish;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic x, input logic [10:0] a,
                          input logic [15:0] wd, input logic [7:0] cnt);
        int t0;
        mx16 = x;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_x16 = x; req_addr = a;
        req_wdata = wd; req_cnt = cnt;
        @(negedge clk);
        req_valid = 1'b0;
        t0 = cyc; nwords = 0;
        while (1) begin
            if (rd_valid && nwords < 8) begin got[nwords] = rd_data; nwords++; end
            if (done) begin got_err = err; break; end
            @(negedge clk);
        end
        op_cycles = cyc - t0;
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [2:0]  op;
        logic        x16;
        logic [10:0] addr;
        logic [15:0] wd;
        logic [15:0] exp;
        logic [6:0]  clks;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{3'd5, 1'b1, 11'h000, 16'h0000, 16'h0000, 7'd13},
        '{3'd1, 1'b1, 11'h005, 16'hA5C3, 16'h0000, 7'd29},
        '{3'd0, 1'b1, 11'h005, 16'h0000, 16'hA5C3, 7'd29},
        '{3'd5, 1'b0, 11'h000, 16'h0000, 16'h0000, 7'd14},
        '{3'd1, 1'b0, 11'h7FF, 16'h003C, 16'h0000, 7'd22},
        '{3'd0, 1'b0, 11'h7FF, 16'h0000, 16'h003C, 7'd22},
        '{3'd2, 1'b1, 11'h005, 16'h0000, 16'h0000, 7'd13},
        '{3'd0, 1'b1, 11'h005, 16'h0000, 16'hFFFF, 7'd29},
        '{3'd6, 1'b1, 11'h000, 16'h0000, 16'h0000, 7'd13},
        '{3'd1, 1'b1, 11'h005, 16'h1234, 16'h0000, 7'd29},
        '{3'd0, 1'b1, 11'h005, 16'h0000, 16'hFFFF, 7'd29}
    };

    initial begin
        int c0;
        logic prog;
        for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 cs", 32'(ew_cs), 32'd0);
        check("R1 sk", 32'(ew_sk), 32'd0);
        check("R1 di", 32'(ew_di), 32'd0);
        check("R1 ready", 32'(req_ready), 32'd1);
        check("R1 done/valid", 32'({done, rd_valid}), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // table walk: frame lengths (R2, R3), data (R6), no-poll ops (R11), clear (R9), codes (R12)
        for (int v = 0; v < 11; v++) begin
            prog = (VECS[v].op >= 3'd1 && VECS[v].op <= 3'd4);
            c0 = clears;
            run_op(VECS[v].op, VECS[v].x16, VECS[v].addr, VECS[v].wd, 8'd1);
            check("R3 frame clocks", 32'(last_clks), 32'(VECS[v].clks));
            check("R11 err low", 32'(got_err), 32'd0);
            check("R9 clear start bits", 32'(clears - c0), prog ? 32'd1 : 32'd0);
            if (VECS[v].op == 3'd0) begin
                check("R6 word count", 32'(nwords), 32'd1);
                check(v == 10 ? "R12 disable kept data" : "R6 read data",
                      32'(got[0]), 32'(VECS[v].exp));
            end
        end

        // R7: multi-word read
        run_op(3'd5, 1'b1, 11'h000, 16'h0, 8'd1);
        run_op(3'd1, 1'b1, 11'h010, 16'h1111, 8'd1);
        run_op(3'd1, 1'b1, 11'h011, 16'h2222, 8'd1);
        run_op(3'd1, 1'b1, 11'h012, 16'h3333, 8'd1);
        run_op(3'd0, 1'b1, 11'h010, 16'h0, 8'd3);
        check("R7 three words", 32'(nwords), 32'd3);
        check("R7 word0", 32'(got[0]), 32'h1111);
        check("R7 word1", 32'(got[1]), 32'h2222);
        check("R7 word2", 32'(got[2]), 32'h3333);
        check("R3 multi-word clocks", 32'(last_clks), 32'd61);
        run_op(3'd0, 1'b1, 11'h011, 16'h0, 8'd0);
        check("R7 count zero", 32'(nwords), 32'd1);
        check("R7 count zero data", 32'(got[0]), 32'h2222);

        // R8: done waits out the busy time
        run_op(3'd1, 1'b1, 11'h020, 16'hBEEF, 8'd1);
        check("R8 waits for ready", 32'(op_cycles >= busy_len), 32'd1);
        check("R8 err", 32'(got_err), 32'd0);

        // R12: write-all and erase-all selectors
        run_op(3'd4, 1'b1, 11'h000, 16'h0F0F, 8'd1);
        run_op(3'd0, 1'b1, 11'h000, 16'h0, 8'd1);
        check("R12 write-all low", 32'(got[0]), 32'h0F0F);
        run_op(3'd0, 1'b1, 11'h3FF, 16'h0, 8'd1);
        check("R12 write-all high", 32'(got[0]), 32'h0F0F);
        run_op(3'd3, 1'b1, 11'h000, 16'h0, 8'd1);
        run_op(3'd0, 1'b1, 11'h200, 16'h0, 8'd1);
        check("R12 erase-all", 32'(got[0]), 32'hFFFF);

        // R10: poll timeout
        busy_len = 5000;
        c0 = clears;
        run_op(3'd2, 1'b1, 11'h001, 16'h0, 8'd1);
        check("R10 timeout err", 32'(got_err), 32'd1);
        check("R10 no clear", 32'(clears - c0), 32'd0);
        busy_len = 60;
        repeat (5100) @(negedge clk);

        // R4 / R5 pin discipline over the whole run
        check("R4 di stable while sk high", 32'(di_glitch), 32'd0);
        check("R4 cs rise with sk low", 32'(cs_sk_bad), 32'd0);
        check("R5 cs low time", 32'(csl_bad), 32'd0);
        check("R1 idle after run", 32'({req_ready, ew_cs}), 32'b10);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule